// File: doc/BRIEF.md
# Page Access Permission Checker

This block sits behind a two-level address translation walk. When a walk completes, the walker presents the flag bits of the directory entry and of the table entry. With them it gives the virtual address, the type of access (read, write or instruction fetch), the privilege of the requester, a reserved-bit indication from the walk, and the write-protect mode. The checker merges the permissions of the two levels and decides whether the access may go ahead. The result appears one clock later through a registered output stage.

When the access is refused, the checker raises a one-cycle fault pulse. It also forms a multi-bit fault code that describes the fault, and captures the faulting virtual address. Two conditions always refuse the access: a missing page and a reserved-bit hit. The fault code and the captured address hold their values until the next fault, so a handler can read them after the pulse has gone. For a large page, the directory entry alone gives the permissions and the table entry is not consulted.

Top module: `page_perm_checker`

## Requirements
- R1: While rst_n is low at a clock edge, every output is zero on the next cycle: res_valid, res_grant, fault_pulse, fault_code and fault_vaddr.
- R2: A request presented with chk_valid high produces res_valid high exactly one cycle later. In that cycle exactly one of res_grant and fault_pulse is high. Without a request, res_valid, res_grant and fault_pulse are all low in the next cycle.
- R3: The page is missing when directory flag bit 0 (present) is clear, or when the page is small and table flag bit 0 is clear. A missing page faults with fault code bit 0 equal to 0. The reserved-bit input is then ignored, so code bit 3 is 0.
- R4: A user access (acc_user=1) is refused unless flag bit 2 (user) is set in both the directory entry and the table entry.
- R5: A user write is refused unless flag bit 1 (writable) is set in both entries.
- R6: A supervisor write to a page that is not writable is allowed when wp_en=0 and refused when wp_en=1.
- R7: The fault code sets bit 1 for a write, bit 2 for a user access and bit 4 for an instruction fetch. A fetch counts as a read: when acc_fetch=1, acc_write has no effect on the decision or on bit 1.
- R8: A present page with rsvd_hit=1 faults with fault code bit 0 = 1 and bit 3 = 1.
- R9: A faulting present page that breaks a permission rule reports bit 0 = 1. Code bits 5 and above are always 0.
- R10: On each fault, fault_vaddr takes the request's virtual address and fault_code takes the new code. Both hold unchanged across grants and idle cycles until the next fault.
- R11: When directory flag bit 7 (large page) is set, the table flags are ignored. Present, writable and user then come from the directory entry alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chk_valid | input | 1 | A completed translation is presented this cycle |
| chk_vaddr | input | VA_W | Virtual address of the access |
| dir_flags | input | FLAG_W | Low flag bits of the directory entry |
| tbl_flags | input | FLAG_W | Low flag bits of the table entry |
| rsvd_hit | input | 1 | Walk found a reserved bit set in an entry |
| acc_write | input | 1 | Access is a write |
| acc_fetch | input | 1 | Access is an instruction fetch |
| acc_user | input | 1 | Access comes from user privilege |
| wp_en | input | 1 | Read-only pages also bind supervisor writes |
| res_valid | output | 1 | Result of last cycle's request is present |
| res_grant | output | 1 | Access allowed |
| fault_pulse | output | 1 | One-cycle fault indication |
| fault_code | output | ERR_W | Fault code of the latest fault |
| fault_vaddr | output | VA_W | Virtual address of the latest fault |

## Verification
The bench aims at the places where the two levels disagree. A user page in the directory over a supervisor table entry must be refused. A checker that used only one level would grant it. Large pages with garbage table flags must be decided by the directory alone. A design that still merged the table flags would fault present pages or grant the wrong privilege. The bench also covers supervisor writes to read-only pages in both write-protect modes, fetches with the write flag set (a design that honoured that flag would report a write), and reserved hits on missing pages (where bit 3 must stay clear). Between faults it checks that the held code and address do not move on grants or idle cycles.

// File: rtl/perm_pkg.sv
// Package: flag bit positions and the merged permission type shared by the
// permission checker modules. Assumes the entry flag layout of a two-level
// page walk, with bit 7 of the directory entry selecting a large page.
package perm_pkg;
    localparam int FLG_PRESENT = 0;
    localparam int FLG_WRITE   = 1;
    localparam int FLG_USER    = 2;
    localparam int FLG_LARGE   = 7;

    localparam int EC_PRESENT = 0;
    localparam int EC_WRITE   = 1;
    localparam int EC_USER    = 2;
    localparam int EC_RSVD    = 3;
    localparam int EC_FETCH   = 4;
    localparam int EC_USED    = 5;

    typedef struct packed {
        logic present;
        logic writable;
        logic user;
    } perm_t;
endpackage

// File: rtl/perm_merge.sv
// Module: perm_merge
// Combines directory and table flags into one effective permission set.
// Assumes FLAG_W > FLG_LARGE. With LARGE_PAGE_EN=0 the large-page bit is not
// decoded and both levels are always merged.
module perm_merge #(
    parameter int FLAG_W        = 12,
    parameter bit LARGE_PAGE_EN = 1'b1
) (
    input  logic [FLAG_W-1:0] dir_flags,
    input  logic [FLAG_W-1:0] tbl_flags,
    output perm_pkg::perm_t   eff
);
    import perm_pkg::*;

    logic large_pg;
    logic unused_flag_bits;

    // Fold the bits this module does not decode.
    assign unused_flag_bits = ^{dir_flags, tbl_flags};

    generate
        if (LARGE_PAGE_EN) begin : g_large
            assign large_pg = dir_flags[FLG_LARGE];
        end else begin : g_small_only
            assign large_pg = 1'b0;
        end
    endgenerate

    // Each permission needs the directory bit and, for small pages, the table bit.
    always_comb begin
        eff.present  = dir_flags[FLG_PRESENT] & (large_pg | tbl_flags[FLG_PRESENT]);
        eff.writable = dir_flags[FLG_WRITE]   & (large_pg | tbl_flags[FLG_WRITE]);
        eff.user     = dir_flags[FLG_USER]    & (large_pg | tbl_flags[FLG_USER]);
    end
endmodule

// File: rtl/perm_decide.sv
// Module: perm_decide
// Decides whether an access is allowed under the merged permissions and
// forms the fault code. Purely combinational. Assumes ERR_W >= EC_USED.
// An instruction fetch is treated as a read.
module perm_decide #(
    parameter int ERR_W = 16
) (
    input  perm_pkg::perm_t    eff,
    input  logic               rsvd_hit,
    input  logic               acc_write,
    input  logic               acc_fetch,
    input  logic               acc_user,
    input  logic               wp_en,
    output logic               deny,
    output logic [ERR_W-1:0]   code
);
    import perm_pkg::*;

    logic is_write;
    logic rsvd_eff;
    logic user_ok;
    logic write_ok;

    // A fetch never writes; a reserved hit counts only on a present page.
    assign is_write = acc_write & ~acc_fetch;
    assign rsvd_eff = rsvd_hit & eff.present;

    // Privilege and write rules; supervisor writes bypass read-only unless wp_en.
    always_comb begin
        user_ok  = ~acc_user | eff.user;
        write_ok = ~is_write | eff.writable | (~acc_user & ~wp_en);
        deny     = ~eff.present | rsvd_eff | ~user_ok | ~write_ok;
    end

    // Fault code: fixed bit positions, every other bit zero.
    always_comb begin
        code              = '0;
        code[EC_PRESENT]  = eff.present;
        code[EC_WRITE]    = is_write;
        code[EC_USER]     = acc_user;
        code[EC_RSVD]     = rsvd_eff;
        code[EC_FETCH]    = acc_fetch;
    end
endmodule

// File: rtl/page_perm_checker.sv
// Module: page_perm_checker (top)
// Checks a completed translation against user/supervisor and read/write
// rules and registers the result. On a fault it pulses fault_pulse for one
// cycle and captures the fault code and virtual address until the next fault.
// Assumes a synchronous active-low reset and one request per cycle at most.
module page_perm_checker #(
    parameter int VA_W          = 32,
    parameter int FLAG_W        = 12,
    parameter int ERR_W         = 16,
    parameter bit LARGE_PAGE_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chk_valid,
    input  logic [VA_W-1:0]   chk_vaddr,
    input  logic [FLAG_W-1:0] dir_flags,
    input  logic [FLAG_W-1:0] tbl_flags,
    input  logic              rsvd_hit,
    input  logic              acc_write,
    input  logic              acc_fetch,
    input  logic              acc_user,
    input  logic              wp_en,
    output logic              res_valid,
    output logic              res_grant,
    output logic              fault_pulse,
    output logic [ERR_W-1:0]  fault_code,
    output logic [VA_W-1:0]   fault_vaddr
);
    import perm_pkg::*;

    localparam int HI_W = ERR_W - EC_USED;

    perm_t            eff;
    logic             deny;
    logic [ERR_W-1:0] code_c;

    perm_merge #(
        .FLAG_W        (FLAG_W),
        .LARGE_PAGE_EN (LARGE_PAGE_EN)
    ) merge_i (
        .dir_flags (dir_flags),
        .tbl_flags (tbl_flags),
        .eff       (eff)
    );

    perm_decide #(
        .ERR_W (ERR_W)
    ) decide_i (
        .eff       (eff),
        .rsvd_hit  (rsvd_hit),
        .acc_write (acc_write),
        .acc_fetch (acc_fetch),
        .acc_user  (acc_user),
        .wp_en     (wp_en),
        .deny      (deny),
        .code      (code_c)
    );

    // Result stage: valid, grant and the one-cycle fault pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid   <= 1'b0;
            res_grant   <= 1'b0;
            fault_pulse <= 1'b0;
        end else begin
            res_valid   <= chk_valid;
            res_grant   <= chk_valid & ~deny;
            fault_pulse <= chk_valid & deny;
        end
    end

    // Fault capture: code and address load on a fault and hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_code  <= '0;
            fault_vaddr <= '0;
        end else if (chk_valid && deny) begin
            fault_code  <= code_c;
            fault_vaddr <= chk_vaddr;
        end
    end

    // R2
    result_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_grant ^ fault_pulse));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid |=> (!res_valid && !res_grant && !fault_pulse));

    // R10
    fault_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |=> (fault_pulse |-> fault_vaddr == $past(chk_vaddr)));

    // R10
    hold_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(chk_valid && deny) |=> $stable(fault_code) && $stable(fault_vaddr));

    // R9
    high_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_code[ERR_W-1:EC_USED] == HI_W'(0));

    // R3
    absent_no_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_code[EC_PRESENT] |-> !fault_code[EC_RSVD]);

    // R4
    user_needs_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && acc_user && !dir_flags[FLG_USER]) |=> fault_pulse);
endmodule

// File: tb/page_perm_checker_tb_top.sv
`timescale 1ns/1ps
module page_perm_checker_tb_top;
    localparam int VA_W   = 32;
    localparam int FLAG_W = 12;
    localparam int ERR_W  = 16;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              chk_valid;
    logic [VA_W-1:0]   chk_vaddr;
    logic [FLAG_W-1:0] dir_flags;
    logic [FLAG_W-1:0] tbl_flags;
    logic              rsvd_hit, acc_write, acc_fetch, acc_user, wp_en;
    logic              res_valid, res_grant, fault_pulse;
    logic [ERR_W-1:0]  fault_code;
    logic [VA_W-1:0]   fault_vaddr;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [ERR_W-1:0] exp_code  = '0;
    logic [VA_W-1:0]  exp_vaddr = '0;

    always #2.5 clk = ~clk;

    page_perm_checker #(.VA_W(VA_W), .FLAG_W(FLAG_W), .ERR_W(ERR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid), .chk_vaddr(chk_vaddr),
        .dir_flags(dir_flags), .tbl_flags(tbl_flags), .rsvd_hit(rsvd_hit),
        .acc_write(acc_write), .acc_fetch(acc_fetch), .acc_user(acc_user),
        .wp_en(wp_en), .res_valid(res_valid), .res_grant(res_grant),
        .fault_pulse(fault_pulse), .fault_code(fault_code), .fault_vaddr(fault_vaddr)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Reference model built from the requirements: returns {fault, code}.
    function automatic logic [ERR_W:0] ref_model(
        input logic [FLAG_W-1:0] d, input logic [FLAG_W-1:0] t,
        input logic rs, input logic w, input logic f, input logic u, input logic wp);
        logic lg, pr, wr, us, iw, rse, flt;
        logic [ERR_W-1:0] c;
        lg  = d[7];
        pr  = d[0] & (lg | t[0]);
        wr  = d[1] & (lg | t[1]);
        us  = d[2] & (lg | t[2]);
        iw  = w & ~f;
        rse = rs & pr;
        flt = ~pr | rse | (u & ~us) | (iw & ~wr & (u | wp));
        c   = '0;
        c[0] = pr; c[1] = iw; c[2] = u; c[3] = rse; c[4] = f;
        return {flt, c};
    endfunction

    // Drive one request at a falling edge, then check at the next falling edge.
    task automatic run_req(input string req, input logic [VA_W-1:0] va,
                           input logic [FLAG_W-1:0] d, input logic [FLAG_W-1:0] t,
                           input logic rs, input logic w, input logic f,
                           input logic u, input logic wp);
        logic [ERR_W:0] r;
        chk_valid = 1'b1; chk_vaddr = va; dir_flags = d; tbl_flags = t;
        rsvd_hit = rs; acc_write = w; acc_fetch = f; acc_user = u; wp_en = wp;
        r = ref_model(d, t, rs, w, f, u, wp);
        if (r[ERR_W]) begin
            exp_code  = r[ERR_W-1:0];
            exp_vaddr = va;
        end
        @(negedge clk);
        check({req, " R2 valid"}, 64'(res_valid), 64'(1));
        check({req, " R10 pulse"}, 64'(fault_pulse), 64'(r[ERR_W]));
        check({req, " grant"}, 64'(res_grant), 64'(!r[ERR_W]));
        check({req, " R9 code"}, 64'(fault_code), 64'(exp_code));
        check({req, " R10 vaddr"}, 64'(fault_vaddr), 64'(exp_vaddr));
    endtask

    task automatic idle_cycle();
        chk_valid = 1'b0;
        chk_vaddr = $urandom;
        @(negedge clk);
        check("R2 idle valid", 64'(res_valid), 64'(0));
        check("R2 idle pulse", 64'(fault_pulse | res_grant), 64'(0));
        check("R10 idle hold code", 64'(fault_code), 64'(exp_code));
        check("R10 idle hold vaddr", 64'(fault_vaddr), 64'(exp_vaddr));
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        rst_n = 1'b0; chk_valid = 1'b1; chk_vaddr = 32'hDEAD_BEEF;
        dir_flags = '0; tbl_flags = '0; rsvd_hit = 1'b1;
        acc_write = 1'b1; acc_fetch = 1'b0; acc_user = 1'b1; wp_en = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 valid", 64'(res_valid), 64'(0));
        check("R1 grant", 64'(res_grant), 64'(0));
        check("R1 pulse", 64'(fault_pulse), 64'(0));
        check("R1 code", 64'(fault_code), 64'(0));
        check("R1 vaddr", 64'(fault_vaddr), 64'(0));
        rst_n = 1'b1;
        idle_cycle();

        // R4: user page in directory over supervisor table entry
        run_req("R4 dir-only user", 32'h1000_0000, 12'h007, 12'h003, 0, 0, 0, 1, 0);
        run_req("R4 both user", 32'h1000_1000, 12'h007, 12'h007, 0, 0, 0, 1, 0);
        run_req("R4 table-only user", 32'h1000_2000, 12'h003, 12'h007, 0, 0, 0, 1, 0);
        // R5: user write to read-only
        run_req("R5 user ro write", 32'h2000_0000, 12'h007, 12'h005, 0, 1, 0, 1, 0);
        run_req("R5 user rw write", 32'h2000_1000, 12'h007, 12'h007, 0, 1, 0, 1, 1);
        // R6: supervisor write to read-only in both modes
        run_req("R6 sup ro wp0", 32'h3000_0000, 12'h005, 12'h005, 0, 1, 0, 0, 0);
        run_req("R6 sup ro wp1", 32'h3000_1000, 12'h005, 12'h005, 0, 1, 0, 0, 1);
        // R3: missing pages, reserved ignored
        run_req("R3 dir absent", 32'h4000_0000, 12'h006, 12'h007, 1, 0, 0, 0, 0);
        run_req("R3 tbl absent", 32'h4000_1000, 12'h007, 12'h006, 1, 1, 0, 1, 0);
        // R8: reserved on present page
        run_req("R8 rsvd", 32'h5000_0000, 12'h007, 12'h007, 1, 0, 0, 0, 0);
        // R7: fetch with write flag set on read-only page
        run_req("R7 fetch ignores write", 32'h6000_0000, 12'h005, 12'h005, 0, 1, 1, 1, 1);
        run_req("R7 fetch fault code", 32'h6000_1000, 12'h001, 12'h001, 0, 1, 1, 1, 1);
        idle_cycle();
        // R11: large page ignores table flags
        run_req("R11 large user", 32'h7040_0000, 12'h087, 12'h000, 0, 1, 0, 1, 1);
        run_req("R11 large sup-only", 32'h7080_0000, 12'h083, 12'hFFF, 0, 0, 0, 1, 0);
        run_req("R11 large absent", 32'h70C0_0000, 12'h086, 12'hFFF, 0, 0, 0, 0, 0);

        // Constrained random mix, present bits biased high.
        for (int i = 0; i < 600; i++) begin
            logic [FLAG_W-1:0] d, t;
            d = FLAG_W'($urandom); t = FLAG_W'($urandom);
            if ($urandom_range(3) != 0) d[0] = 1'b1;
            if ($urandom_range(3) != 0) t[0] = 1'b1;
            if ($urandom_range(5) == 0) idle_cycle();
            run_req("R9 random", $urandom, d, t, ($urandom_range(7) == 0),
                    1'($urandom), ($urandom_range(3) == 0), 1'($urandom), 1'($urandom));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule